// File: doc/BRIEF.md
# Start/Stop Framed Serial Character Transceiver

This block pairs a serial transmitter and a serial receiver for characters framed by a start bit and a stop element. On the transmit side, a parallel character is accepted through a valid/ready handshake. It is then shifted onto an idle-high line in this order: a low start bit, the data bits with the least significant bit first, an optional parity bit, and a high stop element. The line stays high after the stop element until the next character arrives.

The receive side watches an independent line. It starts timing from the falling edge of each start bit, so drift cannot build up across characters. Each bit is sampled near its centre. The received character is returned right-aligned, together with a parity-error flag and a framing-error flag.

The character length (5 to 8 bits), parity mode (none, even or odd) and stop length (1, 1.5 or 2 bit times) are run-time inputs. They should be held steady while characters are in flight. Both directions share one tick, set by a clock-divider input. A bit lasts 16 ticks, so one bit time is 16 × `cfg_div` clock cycles.

Top module: `serial_char_xcvr`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A character accepted when `tx_valid` and `tx_ready` are both 1 is sent as:
  - a 0 start bit,
  - then 5 + `cfg_len` data bits (`cfg_len` 0..3), least significant first.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. It makes the count of ones in data plus parity even when `cfg_par_odd` is 0, and odd when `cfg_par_odd` is 1.
- R4: The stop element is held high for 16, 24 or 32 ticks when `cfg_stop` is 0, 1 or 2 (3 acts as 2). `tx_ready` returns to 1 only when the stop element ends. The total frame lasts (1 + data bits + parity bit) × 16 ticks plus the stop ticks.
- R5: If the receiver samples 0 at the centre of the stop element, `rx_frm_err` is 1 for that character.
- R6: A low pulse on `rx_line` that is high again at the start bit's midpoint (8 ticks) produces no character.
- R7: On each received character, `rx_valid` is 1 for exactly one clock. In that cycle:
  - `rx_data` holds the data bits right-aligned, with the bits above the character length at 0;
  - both error flags are valid, and the flags are 0 whenever `rx_valid` is 0.
- R8: `rx_par_err` is 1 when parity is enabled and the received data plus parity bit break the selected even/odd rule.
- R9: While `tx_ready` is 1 the transmitter drives `tx_line` high, and `tx_ready` drops in the cycle after a handshake.
- R10: The receiver retimes at every start bit. Back-to-back characters arriving at a bit period 3% shorter than nominal are both received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_div | input | DIV_W | Clock cycles per oversample tick (0 acts as 1) |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_stop | input | 2 | Stop length: 0 one bit, 1 one and a half, 2/3 two bits |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter idle, character accepted when valid |
| tx_line | output | 1 | Serial output, idle high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-clock pulse per received character |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | Stop element read low for this character |

## Verification
The transmit duration is due between 2T−1 and 2T clocks after the handshake edge, where T is the frame length in ticks at a divider of 2. The one-clock spread comes from the free-running tick phase, so the bench counts the busy cycles and accepts exactly that window. A received character is due about half a bit before the stop element ends. The bench therefore catches every `rx_valid` pulse on falling edges into a capture log, and compares entries only after the frame it drove has fully ended, plus a margin. Glitch and framing checks wait several bit times after the stimulus before reading the pulse count, so a late spurious character is still seen.

// File: rtl/serial_char_xcvr.sv
module serial_char_xcvr #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [1:0]       cfg_stop,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_line,
  input  logic             rx_line,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_par_err,
  output logic             rx_frm_err
);
  localparam int TKW  = $clog2(2*OVS) + 1;
  localparam int HALF = OVS / 2;
  localparam logic [TKW-1:0] BIT_END  = TKW'(OVS - 1);
  localparam logic [TKW-1:0] MID_END  = TKW'(HALF - 1);
  localparam logic [TKW-1:0] STOP_1   = TKW'(OVS);
  localparam logic [TKW-1:0] STOP_1H  = TKW'(OVS + HALF);
  localparam logic [TKW-1:0] STOP_2   = TKW'(2*OVS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  // shared oversample tick
  logic [DIV_W-1:0] div_cnt, div_lim;
  logic             tick;
  assign div_lim = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
  assign tick    = (div_cnt >= div_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;

  // transmitter
  st_t            tx_st;
  logic [7:0]     tx_sh;
  logic [TKW-1:0] tx_tk, tx_stop_len;
  logic [3:0]     tx_bit, tx_nbits;
  logic           tx_par, tx_par_on, tx_bit_end;
  logic [7:0]     tx_mask;

  assign tx_mask    = 8'hFF >> (2'd3 - cfg_len);
  assign tx_ready   = (tx_st == S_IDLE);
  assign tx_bit_end = (tx_st == S_STOP) ? (tx_tk == tx_stop_len - 1'b1) : (tx_tk == BIT_END);
  assign tx_line    = (tx_st == S_START) ? 1'b0 :
                      (tx_st == S_DATA)  ? tx_sh[0] :
                      (tx_st == S_PAR)   ? tx_par : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st       <= S_IDLE;
      tx_sh       <= '0;
      tx_tk       <= '0;
      tx_stop_len <= STOP_1;
      tx_bit      <= '0;
      tx_nbits    <= 4'd8;
      tx_par      <= 1'b0;
      tx_par_on   <= 1'b0;
    end else if (tx_st == S_IDLE) begin
      if (tx_valid) begin
        tx_sh       <= tx_data & tx_mask;
        tx_nbits    <= 4'd5 + {2'b00, cfg_len};
        tx_par      <= ^(tx_data & tx_mask) ^ cfg_par_odd;
        tx_par_on   <= cfg_par_en;
        tx_stop_len <= (cfg_stop == 2'd0) ? STOP_1 : (cfg_stop == 2'd1) ? STOP_1H : STOP_2;
        tx_tk       <= '0;
        tx_st       <= S_START;
      end
    end else if (tick) begin
      if (!tx_bit_end) tx_tk <= tx_tk + 1'b1;
      else begin
        tx_tk <= '0;
        case (tx_st)
          S_START: begin tx_bit <= '0; tx_st <= S_DATA; end
          S_DATA: begin
            tx_sh  <= tx_sh >> 1;
            tx_bit <= tx_bit + 1'b1;
            if (tx_bit == tx_nbits - 1'b1) tx_st <= tx_par_on ? S_PAR : S_STOP;
          end
          S_PAR:   tx_st <= S_STOP;
          default: tx_st <= S_IDLE;
        endcase
      end
    end
  end

  // receiver
  st_t            rx_st;
  logic           rx_s1, rx_s2, rx_par_bit, rx_par_on, rx_odd;
  logic [7:0]     rx_sh, rx_aligned;
  logic [1:0]     rx_len;
  logic [3:0]     rx_bit;
  logic [TKW-1:0] rx_tk;

  assign rx_aligned = rx_sh >> (2'd3 - rx_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_line;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st      <= S_IDLE;
      rx_sh      <= '0;
      rx_len     <= '0;
      rx_bit     <= '0;
      rx_tk      <= '0;
      rx_par_bit <= 1'b0;
      rx_par_on  <= 1'b0;
      rx_odd     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      case (rx_st)
        S_IDLE:
          if (!rx_s2) begin
            rx_tk <= '0;
            rx_st <= S_START;
          end
        S_START:
          if (tick) begin
            if (rx_tk != MID_END) rx_tk <= rx_tk + 1'b1;
            else if (rx_s2) rx_st <= S_IDLE;
            else begin
              rx_tk     <= '0;
              rx_bit    <= '0;
              rx_len    <= cfg_len;
              rx_par_on <= cfg_par_en;
              rx_odd    <= cfg_par_odd;
              rx_st     <= S_DATA;
            end
          end
        default:
          if (tick) begin
            if (rx_tk != BIT_END) rx_tk <= rx_tk + 1'b1;
            else begin
              rx_tk <= '0;
              if (rx_st == S_DATA) begin
                rx_sh  <= {rx_s2, rx_sh[7:1]};
                rx_bit <= rx_bit + 1'b1;
                if (rx_bit == 4'd4 + {2'b00, rx_len}) rx_st <= rx_par_on ? S_PAR : S_STOP;
              end else if (rx_st == S_PAR) begin
                rx_par_bit <= rx_s2;
                rx_st      <= S_STOP;
              end else begin
                rx_data    <= rx_aligned;
                rx_valid   <= 1'b1;
                rx_par_err <= rx_par_on & (^rx_aligned ^ rx_par_bit ^ rx_odd);
                rx_frm_err <= ~rx_s2;
                rx_st      <= S_IDLE;
              end
            end
          end
      endcase
    end
  end
endmodule

// File: rtl/serial_char_xcvr_chk.sv
module serial_char_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_len,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_line,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_par_err,
  input logic       rx_frm_err
);
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> tx_line);
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_valid && tx_ready |=> !tx_ready);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(tx_ready) |-> !tx_line);
  // R4
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_ready) |-> $past(tx_line));
  // R7
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> (rx_data >> (5 + cfg_len)) == 8'h00);
  // R7
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |-> !rx_par_err && !rx_frm_err);
endmodule

bind serial_char_xcvr serial_char_xcvr_chk u_chk (.*);

// File: tb/serial_char_xcvr_test.sv
`timescale 1ns/1ps
module serial_char_xcvr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd2;
  logic [1:0]  cfg_len = 2'd3, cfg_stop = 2'd0;
  logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_line, rx_valid, rx_par_err, rx_frm_err;
  logic [7:0]  rx_data;
  logic        loop = 1'b1, drv = 1'b1;
  wire         rx_line = loop ? tx_line : drv;

  int nvec = 0, nfail = 0, got = 0;
  logic [7:0] cap_d [32];
  logic       cap_p [32];
  logic       cap_f [32];

  always #10 clk = ~clk;

  serial_char_xcvr uut (.clk, .rst_n, .cfg_div, .cfg_len, .cfg_par_en, .cfg_par_odd,
    .cfg_stop, .tx_data, .tx_valid, .tx_ready, .tx_line, .rx_line, .rx_data,
    .rx_valid, .rx_par_err, .rx_frm_err);

  always @(negedge clk) if (rx_valid && got < 32) begin
    cap_d[got] = rx_data; cap_p[got] = rx_par_err; cap_f[got] = rx_frm_err; got++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  // {len, par_en, par_odd, stop, data}
  localparam logic [13:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 2'd0, 8'h55}, {2'd0, 1'b0, 1'b0, 2'd0, 8'hFF},
    {2'd1, 1'b1, 1'b0, 2'd1, 8'hC3}, {2'd2, 1'b1, 1'b1, 2'd2, 8'hFE},
    {2'd3, 1'b1, 1'b1, 2'd1, 8'h00}, {2'd3, 1'b1, 1'b0, 2'd2, 8'h96},
    {2'd2, 1'b0, 1'b0, 2'd1, 8'h2A}, {2'd0, 1'b1, 1'b1, 2'd0, 8'h0B}};

  task automatic drive_frame(input logic [7:0] d, input int nb, input bit pe, input bit pv,
                             input bit stop_lvl, input int per, input int stop_hold);
    drv = 1'b0; repeat (per) @(negedge clk);
    for (int i = 0; i < nb; i++) begin drv = d[i]; repeat (per) @(negedge clk); end
    if (pe) begin drv = pv; repeat (per) @(negedge clk); end
    drv = stop_lvl; repeat (stop_hold) @(negedge clk);
    drv = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_line", int'(tx_line), 1);
    chk("R1 tx_ready", int'(tx_ready), 1);
    chk("R1 rx_valid", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      automatic logic [7:0] d = VEC[v][7:0];
      automatic int nb = 5 + int'(VEC[v][13:12]);
      automatic int pe = int'(VEC[v][11]);
      automatic int st = int'(VEC[v][9:8]);
      automatic int stt = (st == 0) ? 16 : (st == 1) ? 24 : 32;
      automatic int t = (1 + nb + pe) * 16 + stt;
      automatic logic [7:0] exp = d & (8'hFF >> (8 - nb));
      automatic int g0 = got, busy = 0;
      cfg_len = VEC[v][13:12]; cfg_par_en = VEC[v][11]; cfg_par_odd = VEC[v][10];
      cfg_stop = VEC[v][9:8]; tx_data = d; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      while (!tx_ready && busy < 2000) begin busy++; @(negedge clk); end
      // R4 frame duration incl. stop element; R2/R3 shape the length
      chk("R4 duration lo", int'(busy >= 2*t - 1), 1);
      chk("R4 duration hi", int'(busy <= 2*t), 1);
      repeat (4) @(negedge clk);
      chk("R7 one pulse", got - g0, 1);
      // R2 R7 data right-aligned, R3 parity round trip clean
      chk("R2 data", int'(cap_d[g0]), int'(exp));
      chk("R3 par_err", int'(cap_p[g0]), 0);
      chk("R5 frm_err", int'(cap_f[g0]), 0);
      chk("R9 idle high", int'(tx_line), 1);
      repeat (20) @(negedge clk);
    end

    loop = 1'b0;
    repeat (10) @(negedge clk);

    // R8 wrong even parity on 8 bits of A5 (parity should be 0)
    begin
      automatic int g0 = got;
      cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop = 2'd0;
      drive_frame(8'hA5, 8, 1'b1, 1'b1, 1'b1, 32, 32);
      repeat (40) @(negedge clk);
      chk("R8 count", got - g0, 1);
      chk("R8 data", int'(cap_d[g0]), 8'hA5);
      chk("R8 par_err", int'(cap_p[g0]), 1);
      chk("R8 frm_err", int'(cap_f[g0]), 0);
    end

    // R3 odd parity, 5 bits 13h has 3 ones -> parity 0 correct
    begin
      automatic int g0 = got;
      cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      drive_frame(8'h13, 5, 1'b1, 1'b0, 1'b1, 32, 32);
      repeat (40) @(negedge clk);
      chk("R3 data", int'(cap_d[g0]), 8'h13);
      chk("R3 odd ok", int'(cap_p[g0]), 0);
    end

    // R5 stop element low
    begin
      automatic int g0 = got;
      cfg_len = 2'd2; cfg_par_en = 1'b0;
      drive_frame(8'h3C, 7, 1'b0, 1'b0, 1'b0, 32, 24);
      repeat (200) @(negedge clk);
      chk("R5 count", got - g0, 1);
      chk("R5 data", int'(cap_d[g0]), 8'h3C);
      chk("R5 frm_err", int'(cap_f[g0]), 1);
    end

    // R6 short low pulse
    begin
      automatic int g0 = got;
      drv = 1'b0; repeat (4) @(negedge clk); drv = 1'b1;
      repeat (400) @(negedge clk);
      chk("R6 no char", got - g0, 0);
    end

    // R10 back-to-back at 31-clock bit period
    begin
      automatic int g0 = got;
      cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 2'd0;
      drive_frame(8'h81, 8, 1'b0, 1'b0, 1'b1, 31, 31);
      drive_frame(8'h7E, 8, 1'b0, 1'b0, 1'b1, 31, 31);
      repeat (60) @(negedge clk);
      chk("R10 count", got - g0, 2);
      chk("R10 first", int'(cap_d[g0]), 8'h81);
      chk("R10 second", int'(cap_d[g0 + 1]), 8'h7E);
      chk("R10 frm_err", int'(cap_f[g0 + 1]), 0);
    end

    summary();
  end
endmodule